// File: doc/BRIEF.md
# Bridge Claim Decoder

This block sits on the secondary side of a downstream bridge and decides, once per address phase, whether the bridge takes a memory or I/O cycle and how. A cycle that falls inside one of the bridge's programmed windows, or inside the legacy display ranges when that feature is on, is taken by fast decode and flagged one clock later on `claim_pos`. A cycle that nobody claims is taken as a fallback through `claim_sub`. This happens only when memory-space or I/O-space access is enabled for that cycle type, and only after a fixed wait of `SUB_DELAY` clocks during which no other agent has spoken up.

The block also applies the legacy ISA alias hole to the I/O window and honours an address-parity flag. A cycle that carries an address parity error is never taken by either path, because forwarding it would hide the corruption from the rest of the system. Window registers and control bits are plain inputs that are held steady by the surrounding configuration logic.

Top module: `bridge_claim_decoder`

## Requirements
- R1: A memory cycle (`is_io`=0) with `mem_base` <= `addr` <= `mem_limit`, both bounds inclusive, raises `claim_pos` only when `mem_en` is 1.
- R2: An I/O cycle (`is_io`=1) raises `claim_pos` by window decode only when `io_en` is 1, `addr[63:16]` is zero, and `io_base` <= `addr[15:0]` <= `io_limit`.
- R3: When `isa_en` is 1, an I/O address with `addr[9:8]` nonzero (offset 100h to 3FFh of its 1 KB block) is not taken by window decode.
- R4: When `vga_en` is 1, memory A0000h to BFFFFh (`addr[63:17]`=5) and I/O addresses whose `addr[9:0]` lies in 3B0h to 3BBh or 3C0h to 3DFh are taken positively. The usual enable bit and the 16-bit I/O limit still apply. This display match overrides the ISA hole and ignores `addr[15:10]`.
- R5: A memory cycle that is not positively decoded, with `mem_en` = 1, raises `claim_sub` when no other claim appears in time. Any 64-bit address qualifies.
- R6: An I/O cycle that is not positively decoded, with `io_en` = 1 and `addr[63:16]` zero, raises `claim_sub` when no other claim appears in time. This includes addresses dropped by the ISA hole.
- R7: `claim_sub` is high for exactly the one cycle that follows the `SUB_DELAY`-th rising edge after the address edge. It fires only if `other_claim` was low on the address edge and on each of the `SUB_DELAY` edges after it. If `other_claim` is seen on any of those edges, there is no claim.
- R8: An address phase with `addr_perr` = 1 yields neither `claim_pos` nor `claim_sub`.
- R9: `claim_pos` is a one-cycle strobe in the cycle after the address edge. `other_claim` does not affect it, and `claim_pos` and `claim_sub` are never high together.
- R10: While `rst_n` is low, and on the first cycle after release, both claim outputs are low.
- R11: A new address phase abandons any pending fallback wait, so the earlier cycle produces no `claim_sub`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | High for the single address-phase cycle |
| is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| addr | input | 64 | Cycle address |
| addr_perr | input | 1 | Address parity error seen on this address phase |
| other_claim | input | 1 | Another agent has claimed the current cycle |
| mem_en | input | 1 | Memory-space enable |
| io_en | input | 1 | I/O-space enable |
| isa_en | input | 1 | Apply ISA alias hole to I/O window decode |
| vga_en | input | 1 | Positive decode of legacy display ranges |
| io_base | input | 16 | I/O window lower bound (inclusive) |
| io_limit | input | 16 | I/O window upper bound (inclusive) |
| mem_base | input | 64 | Memory window lower bound (inclusive) |
| mem_limit | input | 64 | Memory window upper bound (inclusive) |
| claim_pos | output | 1 | Positive claim strobe |
| claim_sub | output | 1 | Subtractive claim strobe |

## Verification
The assertions assume that `addr_valid` marks a single cycle and that `addr_perr` only has meaning in that cycle. They also assume the window and control inputs do not change during an address phase or the wait that follows it. The directed stimulus holds every control and window input constant from the address cycle until the observation window closes. It raises `addr_valid` only once per scenario, except in the one test that deliberately starts a second address phase during a pending wait. `other_claim` is pulsed at chosen edges relative to the address edge so that the edge where cancellation stops working can be located exactly.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic {
    WT_IDLE = 1'b0,
    WT_RUN  = 1'b1
  } wait_state_t;

  // Offset 100h..3FFh within any 1 KB I/O block
  function automatic logic isa_alias_hole(input logic [9:0] lo10);
    return (lo10[9:8] != 2'b00);
  endfunction

  // Legacy display I/O: 3B0h..3BBh and 3C0h..3DFh, aliased on bits [9:0]
  function automatic logic vga_io_hit(input logic [9:0] lo10);
    logic mono, color;
    mono  = (lo10 >= 10'h3B0) && (lo10 <= 10'h3BB);
    color = (lo10 >= 10'h3C0) && (lo10 <= 10'h3DF);
    return mono | color;
  endfunction

endpackage

// File: rtl/bcd_window_match.sv
module bcd_window_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] value,
  output logic         hit
);
  always_comb begin
    hit = (value >= lo) && (value <= hi);
  end
endmodule

// File: rtl/bcd_legacy_ranges.sv
module bcd_legacy_ranges #(
  parameter int ADDR_W = 64,
  parameter int IO_W   = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              io_short,
  output logic              hole,
  output logic              vga_io,
  output logic              vga_mem
);
  import bcd_pkg::*;

  localparam int VGA_SHIFT = 17;
  localparam logic [ADDR_W-VGA_SHIFT-1:0] VGA_MEM_TAG = 5; // A0000h..BFFFFh

  always_comb begin
    io_short = (addr[ADDR_W-1:IO_W] == '0);
    hole     = isa_alias_hole(addr[9:0]);
    vga_io   = vga_io_hit(addr[9:0]);
    vga_mem  = (addr[ADDR_W-1:VGA_SHIFT] == VGA_MEM_TAG);
  end
endmodule

// File: rtl/bcd_sub_timer.sv
module bcd_sub_timer #(
  parameter int SUB_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_i,   // address phase this cycle
  input  logic start_i,   // fallback eligible on this address phase
  input  logic other_i,   // another agent claimed
  output logic fire_o
);
  import bcd_pkg::*;

  localparam int CNT_W = (SUB_DELAY < 2) ? 1 : $clog2(SUB_DELAY);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SUB_DELAY - 1);

  wait_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (phase_i) begin
      if (start_i && !other_i) begin
        st_d  = WT_RUN;
        cnt_d = LOAD;
      end else begin
        st_d = WT_IDLE;
      end
    end else if (st_q == WT_RUN) begin
      if (other_i) begin
        st_d = WT_IDLE;
      end else if (cnt_q == '0) begin
        fire_d = 1'b1;
        st_d   = WT_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WT_IDLE;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o = fire_q;

  // R7: a claim by another agent on an edge suppresses the fallback strobe
  p_other_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    other_i |=> !fire_o);
  // R11: a new address phase never lets an old wait complete
  p_phase_aborts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_i |=> !fire_o);
  // R7: the strobe only leaves a running wait
  p_fire_from_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(st_q == WT_RUN));
endmodule

// File: rtl/bridge_claim_decoder.sv
module bridge_claim_decoder #(
  parameter int ADDR_W    = 64,
  parameter int IO_W      = 16,
  parameter int SUB_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_perr,
  input  logic              other_claim,
  input  logic              mem_en,
  input  logic              io_en,
  input  logic              isa_en,
  input  logic              vga_en,
  input  logic [IO_W-1:0]   io_base,
  input  logic [IO_W-1:0]   io_limit,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] mem_limit,
  output logic              claim_pos,
  output logic              claim_sub
);

  logic io_short, hole, vga_io, vga_mem;
  logic io_win_hit, mem_win_hit;
  logic pos_mem, pos_io, pos_hit;
  logic sub_ok;
  logic pos_q, pos_d;
  logic sub_fire;

  bcd_legacy_ranges #(.ADDR_W(ADDR_W), .IO_W(IO_W)) i_legacy (
    .addr     (addr),
    .io_short (io_short),
    .hole     (hole),
    .vga_io   (vga_io),
    .vga_mem  (vga_mem)
  );

  bcd_window_match #(.W(IO_W)) i_io_win (
    .lo    (io_base),
    .hi    (io_limit),
    .value (addr[IO_W-1:0]),
    .hit   (io_win_hit)
  );

  bcd_window_match #(.W(ADDR_W)) i_mem_win (
    .lo    (mem_base),
    .hi    (mem_limit),
    .value (addr),
    .hit   (mem_win_hit)
  );

  always_comb begin
    pos_mem = !is_io && mem_en && (mem_win_hit || (vga_en && vga_mem));
    pos_io  = is_io && io_en && io_short &&
              ((io_win_hit && !(isa_en && hole)) || (vga_en && vga_io));
    pos_hit = pos_mem || pos_io;
    sub_ok  = !pos_hit && !addr_perr &&
              (is_io ? (io_en && io_short) : mem_en);
    pos_d   = addr_valid && pos_hit && !addr_perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
    end
  end

  bcd_sub_timer #(.SUB_DELAY(SUB_DELAY)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (addr_valid),
    .start_i (sub_ok),
    .other_i (other_claim),
    .fire_o  (sub_fire)
  );

  assign claim_pos = pos_q;
  assign claim_sub = sub_fire;

  // R9: the two claim kinds never coincide
  p_claims_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_pos && claim_sub));
  // R9: positive strobe only follows an address phase
  p_pos_after_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    claim_pos |-> $past(addr_valid));
  // R8: parity-damaged address is never taken positively
  p_perr_no_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_perr) |=> !claim_pos);
  // R1: memory decode needs memory enable
  p_mem_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !is_io && !mem_en) |=> !claim_pos);
  // R2: I/O decode needs I/O enable
  p_io_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && !io_en) |=> !claim_pos);
  // R2: I/O beyond 16 bits is never positively taken
  p_io_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && is_io && (addr[ADDR_W-1:IO_W] != '0)) |=> !claim_pos);
endmodule

// File: tb/test_bridge_claim_decoder.sv
module test_bridge_claim_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int NONE = 0, POS = 1, SUB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_valid = 1'b0, is_io = 1'b0, addr_perr = 1'b0, other_claim = 1'b0;
  logic        mem_en = 1'b1, io_en = 1'b1, isa_en = 1'b0, vga_en = 1'b0;
  logic [63:0] addr = '0;
  logic [15:0] io_base = 16'h1000, io_limit = 16'h1FFF;
  logic [63:0] mem_base = 64'h1_0000_0000, mem_limit = 64'h1_0FFF_FFFF;
  logic        claim_pos, claim_sub;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_claim_decoder #(.ADDR_W(64), .IO_W(16), .SUB_DELAY(D)) i_bridge_claim_decoder (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .is_io(is_io), .addr(addr),
    .addr_perr(addr_perr), .other_claim(other_claim), .mem_en(mem_en), .io_en(io_en),
    .isa_en(isa_en), .vga_en(vga_en), .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit), .claim_pos(claim_pos), .claim_sub(claim_sub)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one address phase; oc_k = edge index at which other_claim is high (-1 none).
  // Outputs seen at negedge k reflect edge k-1: POS expected at k=1, SUB at k=D+1.
  task automatic phase(input string req, input logic io, input logic [63:0] a,
                       input logic perr, input int oc_k, input int expect_kind);
    int pos_n = 0, sub_n = 0, pos_at = -1, sub_at = -1, both = 0;
    @(negedge clk);
    is_io = io; addr = a; addr_perr = perr; addr_valid = 1'b1;
    other_claim = (oc_k == 0);
    for (int k = 1; k <= D + 3; k++) begin
      @(negedge clk);
      if (claim_pos) begin pos_n++; pos_at = k; end
      if (claim_sub) begin sub_n++; sub_at = k; end
      if (claim_pos && claim_sub) both++;
      addr_valid = 1'b0; addr_perr = 1'b0;
      other_claim = (oc_k == k);
    end
    other_claim = 1'b0;
    check(req, "pos count", pos_n, (expect_kind == POS) ? 1 : 0);
    check(req, "sub count", sub_n, (expect_kind == SUB) ? 1 : 0);
    if (expect_kind == POS) check(req, "pos cycle", pos_at, 1);
    if (expect_kind == SUB) check(req, "sub cycle", sub_at, D + 1);
    check("R9", "overlap", both, 0);
  endtask

  task automatic t_reset();
    check("R10", "pos in reset", int'(claim_pos), 0);
    check("R10", "sub in reset", int'(claim_sub), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10", "pos after release", int'(claim_pos), 0);
    check("R10", "sub after release", int'(claim_sub), 0);
  endtask

  task automatic t_mem_window();
    phase("R1", 1'b0, 64'h1_0000_0040, 1'b0, -1, POS);
    phase("R1", 1'b0, 64'h1_0FFF_FFFF, 1'b0, -1, POS);
    phase("R1", 1'b0, 64'h1_0000_0000, 1'b0, -1, POS);
    phase("R5", 1'b0, 64'h1_1000_0000, 1'b0, -1, SUB);
    phase("R5", 1'b0, 64'hF000_0000_0000_0000, 1'b0, -1, SUB);
    mem_en = 1'b0;
    phase("R1", 1'b0, 64'h1_0000_0040, 1'b0, -1, NONE);
    phase("R5", 1'b0, 64'h2_0000_0000, 1'b0, -1, NONE);
    mem_en = 1'b1;
  endtask

  task automatic t_io_window();
    phase("R2", 1'b1, 64'h1010, 1'b0, -1, POS);
    phase("R2", 1'b1, 64'h1FFF, 1'b0, -1, POS);
    phase("R6", 1'b1, 64'h2000, 1'b0, -1, SUB);
    phase("R2", 1'b1, 64'h1_0000_1010, 1'b0, -1, NONE);
    io_en = 1'b0;
    phase("R2", 1'b1, 64'h1010, 1'b0, -1, NONE);
    phase("R6", 1'b1, 64'h2000, 1'b0, -1, NONE);
    io_en = 1'b1;
  endtask

  task automatic t_isa_hole();
    isa_en = 1'b1;
    phase("R3", 1'b1, 64'h1110, 1'b0, -1, SUB);
    phase("R3", 1'b1, 64'h1410, 1'b0, -1, POS);
    phase("R6", 1'b1, 64'h13F0, 1'b0, -1, SUB);
    isa_en = 1'b0;
    phase("R3", 1'b1, 64'h1110, 1'b0, -1, POS);
  endtask

  task automatic t_vga();
    vga_en = 1'b1;
    phase("R4", 1'b0, 64'hA_8000, 1'b0, -1, POS);
    phase("R4", 1'b0, 64'hB_FFFF, 1'b0, -1, POS);
    phase("R4", 1'b0, 64'hC_0000, 1'b0, -1, SUB);
    phase("R4", 1'b1, 64'h3C4, 1'b0, -1, POS);
    phase("R4", 1'b1, 64'h83B5, 1'b0, -1, POS);
    phase("R4", 1'b1, 64'h3BC, 1'b0, -1, SUB);
    isa_en = 1'b1;
    phase("R4", 1'b1, 64'h13D0, 1'b0, -1, POS);
    isa_en = 1'b0;
    mem_en = 1'b0;
    phase("R4", 1'b0, 64'hA_8000, 1'b0, -1, NONE);
    mem_en = 1'b1;
    vga_en = 1'b0;
    phase("R4", 1'b0, 64'hA_8000, 1'b0, -1, SUB);
    phase("R4", 1'b1, 64'h3C4, 1'b0, -1, SUB);
  endtask

  task automatic t_other_claim();
    phase("R7", 1'b0, 64'h5000, 1'b0, 0, NONE);
    phase("R7", 1'b0, 64'h5000, 1'b0, 2, NONE);
    phase("R7", 1'b0, 64'h5000, 1'b0, D, NONE);
    phase("R7", 1'b0, 64'h5000, 1'b0, D + 1, SUB);
    phase("R9", 1'b0, 64'h1_0000_0040, 1'b0, 0, POS);
  endtask

  task automatic t_parity();
    phase("R8", 1'b0, 64'h1_0000_0040, 1'b1, -1, NONE);
    phase("R8", 1'b0, 64'h5000, 1'b1, -1, NONE);
    phase("R8", 1'b1, 64'h1010, 1'b1, -1, NONE);
    phase("R8", 1'b1, 64'h2000, 1'b1, -1, NONE);
  endtask

  task automatic t_restart();
    int pos_n = 0, sub_n = 0;
    @(negedge clk);
    is_io = 1'b0; addr = 64'h5000; addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    @(negedge clk);
    addr = 64'h1_0000_0040; addr_valid = 1'b1;
    for (int k = 1; k <= D + 3; k++) begin
      @(negedge clk);
      addr_valid = 1'b0;
      if (claim_pos) pos_n++;
      if (claim_sub) sub_n++;
    end
    check("R11", "sub after restart", sub_n, 0);
    check("R11", "pos of new phase", pos_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mem_window();
    t_io_window();
    t_isa_hole();
    t_vga();
    t_other_claim();
    t_parity();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule